// File: doc/BRIEF.md
# Short-Stroke Vector Line Stepper

This block walks a current pixel position across the screen under the control of compact vector commands. Each command word holds two 8-bit vectors. Each vector gives a step count along its major axis, a flag that selects drawing or a plain move, and one of eight directions spaced 45 degrees apart. The block runs the two vectors one after the other. It emits one pixel write strobe per drawn point, with the address on its pixel outputs. For a move vector it only updates the position.

A host first places the pen with a position load while the block is idle. It then streams command words through a valid/ready handshake. An option that suppresses the final pixel of each vector lets chained strokes avoid writing shared endpoints twice. Screen Y grows downward. Coordinates are two's-complement and wrap silently.

Top module: `ssv_stepper`

## Requirements
- R1: After reset, busy and the write strobe are low, ready is high, and both current coordinates are zero.
- R2: A position load while idle sets the current X and Y at the next clock edge. A position load while busy is ignored.
- R3: A command word is taken on a clock edge where valid and ready are both high. Ready is low whenever busy is high. A valid asserted while busy does not start a second word.
- R4: Within each 8-bit vector, bits [3:0] hold the length, bit 4 is 1 for draw and 0 for move, and bits [7:5] hold the direction code. The vector in bits [7:0] runs before the vector in bits [15:8].
- R5: Direction codes 0..7 step by (dx,dy) = (+1,0), (+1,-1), (0,-1), (-1,-1), (-1,0), (-1,+1), (0,+1), (+1,+1). Diagonal codes move both axes by one per step.
- R6: A draw vector of length N starting at P takes N+1 cycles. It writes the pixels P + k·(dx,dy) for k = 0..N in order and leaves the current position at P + N·(dx,dy).
- R7: A move vector takes the same N+1 cycles and advances the position identically, but never raises the write strobe.
- R8: The last-pixel-off input is captured when a word is accepted. When it is set, the k = N pixel of every draw vector in that word is not written. For a length-0 vector this means no pixel at all.
- R9: Coordinates are 12-bit two's-complement and wrap modulo 4096, so +1 from 2047 gives -2048.
- R10: Busy stays high for exactly (N0+1)+(N1+1) cycles per word. A new word can be accepted on the first edge after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_load | input | 1 | Load current position (honoured only while idle) |
| pos_x_in | input | 12 | X value to load |
| pos_y_in | input | 12 | Y value to load |
| last_pel_off | input | 1 | Suppress final pixel of each vector of the next accepted word |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Block can accept a command word |
| cmd_word | input | 16 | Two packed vectors |
| pix_we | output | 1 | Pixel write strobe |
| pix_x | output | 12 | Pixel X address |
| pix_y | output | 12 | Pixel Y address |
| cur_x | output | 12 | Current X position |
| cur_y | output | 12 | Current Y position |
| busy | output | 1 | A command word is executing |

## Verification
Every cycle, the assertions check several properties. An accepted word always raises busy. The step counter never passes the active vector's length. Busy only falls after the last step of the final vector. A coordinate never moves by more than one per cycle while busy and holds still when neither stepping nor loading. The decoded direction is diagonal exactly for odd codes. Only the bench scenarios can show the exact pixel sequences, the direction table, endpoint suppression, wrap-around, the per-word cycle count, and that loads and commands arriving during a busy word are ignored.

// File: rtl/ssv_pkg.sv
package ssv_pkg;
   typedef logic signed [1:0] delta_t;
   localparam int DIR_W = 3;
endpackage

// File: rtl/ssv_octant.sv
module ssv_octant
   import ssv_pkg::*;
#(
   parameter bit Y_DOWN = 1'b1
) (
   input  logic [DIR_W-1:0] dir,
   output delta_t           dx,
   output delta_t           dy
);
   delta_t up;

   always_comb begin
      case (dir)
         3'd0:    begin dx = 2'sd1;  up = 2'sd0;  end
         3'd1:    begin dx = 2'sd1;  up = 2'sd1;  end
         3'd2:    begin dx = 2'sd0;  up = 2'sd1;  end
         3'd3:    begin dx = -2'sd1; up = 2'sd1;  end
         3'd4:    begin dx = -2'sd1; up = 2'sd0;  end
         3'd5:    begin dx = -2'sd1; up = -2'sd1; end
         3'd6:    begin dx = 2'sd0;  up = -2'sd1; end
         default: begin dx = 2'sd1;  up = -2'sd1; end
      endcase
   end

   generate
      if (Y_DOWN) begin : g_screen
         assign dy = -up;
      end else begin : g_math
         assign dy = up;
      end
   endgenerate

   // R5
   always_comb begin
      diag_code_chk: assert (((dx != 2'sd0) && (dy != 2'sd0)) == dir[0]);
   end
endmodule

// File: rtl/ssv_axis.sv
module ssv_axis
   import ssv_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          step,
   input  delta_t        delta,
   output logic [CW-1:0] q
);
   generate
      if (CW < 2) begin : g_bad_cw
         $error("ssv_axis: CW must be at least 2");
      end
   endgenerate

   logic [CW-1:0] delta_ext;
   assign delta_ext = {{(CW-2){delta[1]}}, delta};

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_val;
      else if (step) q <= q + delta_ext;
   end

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(q));
endmodule

// File: rtl/ssv_seq.sv
module ssv_seq
   import ssv_pkg::*;
#(
   parameter int LEN_W = 4,
   parameter int NVEC  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [(LEN_W+4)*NVEC-1:0]    cmd_word,
   input  logic                         lpo_in,
   output logic                         cmd_ready,
   output logic                         busy,
   output logic                         step,
   output logic                         we,
   output logic [DIR_W-1:0]             dir
);
   localparam int VEC_W  = LEN_W + 1 + DIR_W;
   localparam int WORD_W = VEC_W * NVEC;
   localparam int IDX_W  = (NVEC > 1) ? $clog2(NVEC) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NVEC - 1);

   generate
      if (LEN_W < 1 || NVEC < 1) begin : g_bad_cfg
         $error("ssv_seq: LEN_W and NVEC must be positive");
      end
   endgenerate

   logic              busy_q;
   logic [IDX_W-1:0]  idx_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [WORD_W-1:0] word_q;
   logic              lpo_q;

   logic [VEC_W-1:0]  cur_vec;
   logic [LEN_W-1:0]  len;
   logic              draw;
   logic              is_last;
   logic              final_vec;
   logic              accept;

   assign cur_vec   = word_q[int'(idx_q)*VEC_W +: VEC_W];
   assign len       = cur_vec[LEN_W-1:0];
   assign draw      = cur_vec[LEN_W];
   assign dir       = cur_vec[VEC_W-1 -: DIR_W];
   assign is_last   = (cnt_q == len);
   assign final_vec = (idx_q == LAST_IDX);
   assign accept    = cmd_valid && !busy_q;

   assign cmd_ready = !busy_q;
   assign busy      = busy_q;
   assign step      = busy_q && !is_last;
   assign we        = busy_q && draw && !(is_last && lpo_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         cnt_q  <= '0;
         word_q <= '0;
         lpo_q  <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         cnt_q  <= '0;
         word_q <= cmd_word;
         lpo_q  <= lpo_in;
      end else if (busy_q) begin
         if (!is_last) begin
            cnt_q <= cnt_q + LEN_W'(1);
         end else if (final_vec) begin
            busy_q <= 1'b0;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
            cnt_q <= '0;
         end
      end
   end

   // R3
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> busy);

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= len));

   // R10
   done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(is_last && final_vec));
endmodule

// File: rtl/ssv_stepper.sv
module ssv_stepper
   import ssv_pkg::*;
#(
   parameter int CW     = 12,
   parameter int LEN_W  = 4,
   parameter int NVEC   = 2,
   parameter bit Y_DOWN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pos_load,
   input  logic [CW-1:0]              pos_x_in,
   input  logic [CW-1:0]              pos_y_in,
   input  logic                       last_pel_off,
   input  logic                       cmd_valid,
   output logic                       cmd_ready,
   input  logic [(LEN_W+4)*NVEC-1:0]  cmd_word,
   output logic                       pix_we,
   output logic [CW-1:0]              pix_x,
   output logic [CW-1:0]              pix_y,
   output logic [CW-1:0]              cur_x,
   output logic [CW-1:0]              cur_y,
   output logic                       busy
);
   localparam int NAX = 2;
   localparam logic [CW-1:0] ONE  = CW'(1);
   localparam logic [CW-1:0] MONE = '1;

   logic             step;
   logic [DIR_W-1:0] dir;
   delta_t           dx, dy;
   logic             axis_load;
   logic [CW-1:0]    load_val [NAX];
   delta_t           delta    [NAX];
   logic [CW-1:0]    pos      [NAX];

   ssv_seq #(.LEN_W(LEN_W), .NVEC(NVEC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_word  (cmd_word),
      .lpo_in    (last_pel_off),
      .cmd_ready (cmd_ready),
      .busy      (busy),
      .step      (step),
      .we        (pix_we),
      .dir       (dir)
   );

   ssv_octant #(.Y_DOWN(Y_DOWN)) u_oct (
      .dir (dir),
      .dx  (dx),
      .dy  (dy)
   );

   assign axis_load   = pos_load && !busy;
   assign load_val[0] = pos_x_in;
   assign load_val[1] = pos_y_in;
   assign delta[0]    = dx;
   assign delta[1]    = dy;

   generate
      for (genvar a = 0; a < NAX; a++) begin : g_axis
         ssv_axis #(.CW(CW)) u_axis (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (axis_load),
            .load_val (load_val[a]),
            .step     (step),
            .delta    (delta[a]),
            .q        (pos[a])
         );
      end
   endgenerate

   assign cur_x = pos[0];
   assign cur_y = pos[1];
   assign pix_x = pos[0];
   assign pix_y = pos[1];

   // R5
   unit_step_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ((CW'(cur_x - $past(cur_x)) == '0) ||
                       (CW'(cur_x - $past(cur_x)) == ONE) ||
                       (CW'(cur_x - $past(cur_x)) == MONE)));

   // R5
   unit_step_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ((CW'(cur_y - $past(cur_y)) == '0) ||
                       (CW'(cur_y - $past(cur_y)) == ONE) ||
                       (CW'(cur_y - $past(cur_y)) == MONE)));
endmodule

// File: tb/ssv_stepper_bench.sv
module ssv_stepper_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pos_load = 1'b0;
   logic [11:0] pos_x_in = '0, pos_y_in = '0;
   logic        last_pel_off = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [15:0] cmd_word = '0;
   logic        pix_we;
   logic [11:0] pix_x, pix_y, cur_x, cur_y;
   logic        busy;

   int checks = 0;
   int fails  = 0;
   int we_seen = 0;
   logic [23:0] exp_q [$];
   logic [11:0] mx = '0, my = '0;

   always #10 clk = ~clk;

   ssv_stepper u_ssv_stepper (
      .clk(clk), .rst_n(rst_n), .pos_load(pos_load), .pos_x_in(pos_x_in),
      .pos_y_in(pos_y_in), .last_pel_off(last_pel_off), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_word(cmd_word), .pix_we(pix_we),
      .pix_x(pix_x), .pix_y(pix_y), .cur_x(cur_x), .cur_y(cur_y), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] vec(input int len, input bit draw, input int dir);
      return {3'(dir), draw, 4'(len)};
   endfunction

   // R5 direction table, Y down
   function automatic void dir_delta(input int d, output logic [11:0] ddx, output logic [11:0] ddy);
      case (d)
         0: begin ddx = 12'd1;   ddy = 12'd0;   end
         1: begin ddx = 12'd1;   ddy = 12'hFFF; end
         2: begin ddx = 12'd0;   ddy = 12'hFFF; end
         3: begin ddx = 12'hFFF; ddy = 12'hFFF; end
         4: begin ddx = 12'hFFF; ddy = 12'd0;   end
         5: begin ddx = 12'hFFF; ddy = 12'd1;   end
         6: begin ddx = 12'd0;   ddy = 12'd1;   end
         default: begin ddx = 12'd1; ddy = 12'd1; end
      endcase
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && pix_we) begin
         we_seen++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected write", int'({pix_x, pix_y}), 0);
         end else begin
            logic [23:0] e;
            e = exp_q.pop_front();
            chk({pix_x, pix_y} == e, "R6 pixel", int'({pix_x, pix_y}), int'(e));
         end
      end
   end

   task automatic load_pos(input logic [11:0] x, input logic [11:0] y);
      @(negedge clk);
      pos_load = 1'b1; pos_x_in = x; pos_y_in = y;
      @(negedge clk);
      pos_load = 1'b0;
      chk(cur_x == x && cur_y == y, "R2 load", int'({cur_x, cur_y}), int'({x, y}));
      mx = x; my = y;
   endtask

   // driver: push expected pixels, apply word, check timing and end point
   task automatic run_word(input logic [15:0] w, input bit lpo, input bit spoil);
      int exp_cyc = 0;
      int exp_we  = 0;
      int cyc     = 0;
      int we0;
      for (int v = 0; v < 2; v++) begin
         logic [7:0]  f;
         logic [11:0] ddx, ddy;
         int n;
         f = w[v*8 +: 8];
         n = int'(f[3:0]);
         dir_delta(int'(f[7:5]), ddx, ddy);
         for (int k = 0; k <= n; k++) begin
            if (f[4] && !(lpo && k == n)) begin
               exp_q.push_back({mx, my});
               exp_we++;
            end
            if (k < n) begin mx = mx + ddx; my = my + ddy; end
         end
         exp_cyc += n + 1;
      end
      while (!cmd_ready) @(negedge clk);
      we0 = we_seen;
      cmd_word = w; last_pel_off = lpo; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; last_pel_off = 1'b0;
      if (spoil) begin
         // R3 / R2: stimulus while busy must be ignored
         chk(cmd_ready == 1'b0, "R3 ready low while busy", int'(cmd_ready), 0);
         cmd_valid = 1'b1; cmd_word = 16'hFFFF;
         pos_load = 1'b1; pos_x_in = 12'h555; pos_y_in = 12'h2AA;
         @(negedge clk);
         cyc++;
         cmd_valid = 1'b0; pos_load = 1'b0;
      end
      while (busy) begin
         cyc++;
         @(negedge clk);
      end
      chk(cyc == exp_cyc, "R10 busy cycles", cyc, exp_cyc);
      chk(we_seen - we0 == exp_we, "R7/R8 write count", we_seen - we0, exp_we);
      chk(cur_x == mx && cur_y == my, "R6/R9 end position", int'({cur_x, cur_y}), int'({mx, my}));
      chk(exp_q.size() == 0, "R6 pixels outstanding", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(busy == 0 && cmd_ready == 1 && pix_we == 0, "R1 reset flags",
          int'({busy, cmd_ready, pix_we}), 3'b010);
      chk(cur_x == 0 && cur_y == 0, "R1 reset position", int'({cur_x, cur_y}), 0);

      load_pos(12'd100, 12'd200);
      // R4 R6: low vector first, draw right 3 then down 2
      run_word({vec(2, 1, 6), vec(3, 1, 0)}, 1'b0, 1'b0);
      // R5: every direction
      run_word({vec(2, 1, 1), vec(1, 1, 0)}, 1'b0, 1'b0);
      run_word({vec(4, 1, 3), vec(3, 1, 2)}, 1'b0, 1'b0);
      run_word({vec(1, 1, 5), vec(2, 1, 4)}, 1'b0, 1'b0);
      run_word({vec(3, 1, 7), vec(5, 1, 6)}, 1'b0, 1'b0);
      // R7: move then draw
      run_word({vec(1, 1, 3), vec(5, 0, 1)}, 1'b0, 1'b0);
      run_word({vec(7, 0, 4), vec(0, 0, 2)}, 1'b0, 1'b0);
      // R8: last pixel off, including length-0 vector
      run_word({vec(0, 1, 0), vec(3, 1, 7)}, 1'b1, 1'b0);
      run_word({vec(2, 1, 2), vec(2, 1, 0)}, 1'b1, 1'b0);
      // R8 length 0 without suppression writes one pixel
      run_word({vec(0, 1, 4), vec(0, 1, 4)}, 1'b0, 1'b0);
      // R9: wrap at both ends
      load_pos(12'h7FF, 12'h800);
      run_word({vec(1, 1, 2), vec(2, 1, 0)}, 1'b0, 1'b0);
      run_word({vec(3, 1, 5), vec(1, 1, 4)}, 1'b0, 1'b0);
      // R2 R3: load and command during busy are ignored
      load_pos(12'd10, 12'd20);
      run_word({vec(15, 1, 6), vec(15, 1, 7)}, 1'b0, 1'b1);
      // R10: back-to-back words
      run_word({vec(1, 1, 0), vec(0, 1, 0)}, 1'b0, 1'b0);
      run_word({vec(0, 0, 0), vec(0, 1, 2)}, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule